// File: doc/BRIEF.md
# Five-Band Equalizer Control Register Slave

This block is a write-only two-wire serial slave that keeps the settings of a five-band stereo equalizer. The bus lines arrive as plain inputs and are resynchronised to the system clock. The slave acknowledges a transfer by pulling the data line low through an output enable. A strap input picks which of two device addresses the slave answers to.

A transfer carries the device address and then a register pointer. One or more setting bytes follow. After each setting byte the pointer moves on to the next band. Each band stores a 3-bit lift code and a 3-bit attenuation code. Band 0 also stores a bypass flag. While the bypass flag is set, every effective code at the outputs reads zero, which is the flat 0 dB state. The stored codes are not altered and come back when the flag is cleared.

Top module: `eq_i2c_regs`

## Requirements
- R1: After reset every stored code and the bypass flag are zero, so `boost_o` and `cut_o` read zero, and `sda_oe_o` is low.
- R2: The slave acknowledges the first byte after a start only if that byte equals 0x84 while `addr_sel_i` is 0, or 0x86 while it is 1. It also acknowledges every following pointer and setting byte of that transfer.
- R3: A first byte that does not match, including a byte with bit 0 (read) set, is not acknowledged. Every later byte is then left unacknowledged until the next start, and no register changes.
- R4: A setting byte written to pointer p in the range 0 to 4 loads bits 6:4 into the lift code of band p and bits 2:0 into its attenuation code. Band p appears at `boost_o[3p+2:3p]` and `cut_o[3p+2:3p]`. Bit 3 has no effect.
- R5: Each setting byte after the first in one transfer goes to the pointer that follows the one used by the previous byte.
- R6: Setting bytes aimed at pointer 5 or above are acknowledged and discarded. This covers bytes sent to such a pointer directly and bytes that run past band 4 during auto-increment.
- R7: Bit 7 of the byte written to band 0 is the bypass flag. While it is 1 all outputs read zero, and the stored codes are kept. Bit 7 written to bands 1 to 4 has no effect.
- R8: A register changes only after its whole byte has been received and acknowledged. A byte cut short by a stop leaves the register unchanged.
- R9: A start that arrives inside a transfer begins address decoding again. The pointer byte that follows it replaces the previous pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address strap: 0 selects 0x84, 1 selects 0x86 |
| sda_oe_o | output | 1 | Pull the data line low (acknowledge) |
| boost_o | output | 15 | Effective lift codes, 3 bits per band, band 0 in the LSBs |
| cut_o | output | 15 | Effective attenuation codes, 3 bits per band, band 0 in the LSBs |

## Verification
The hardest states to reach from the ports are a transfer that is broken off in the middle: a byte stopped after a few bits, or a repeated start issued after a pointer byte has already been accepted. Neither one ever occurs in a well-formed write. The bench therefore builds these cases directly from bit-level tasks that can place a stop or start at any bit. It then confirms that only the byte sent after the restart lands. Random transfers with wrong addresses, read bits, out-of-range pointers and overlong bursts cover the ignore paths.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_BANDS = 5;
  localparam int BYTE_W    = 8;
  localparam int BOOST_LSB = 4;
  localparam int CUT_LSB   = 0;
  localparam int BYP_BIT   = 7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SUB, PH_DATA, PH_SKIP
  } phase_e;
endpackage

// File: rtl/eq_bus_sync.sv
module eq_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
  // data edge while clock held high
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/eq_i2c_rx.sv
module eq_i2c_rx
  import eq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h42,
  parameter int         NUM_REGS  = NUM_BANDS,
  parameter int         IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  phase_e            phase_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] ptr_q;
  logic              oe_q;
  logic [BYTE_W-1:0] my_addr;
  logic              active;
  logic              in_range;

  assign my_addr  = {DEV_ADDR[6:1], addr_sel_i, 1'b0};
  assign active   = (phase_q == PH_ADDR) || (phase_q == PH_SUB) || (phase_q == PH_DATA);
  assign in_range = ptr_q < BYTE_W'(NUM_REGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (active) begin
        if (scl_rise_i && cnt_q < ACK_BIT) begin
          if (cnt_q < LAST_BIT) shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end
        if (scl_fall_i && cnt_q == LAST_BIT) begin
          if (phase_q == PH_ADDR && shreg_q != my_addr) phase_q <= PH_SKIP;
          else                                          oe_q    <= 1'b1;
        end
        if (scl_fall_i && cnt_q == ACK_BIT) begin
          oe_q  <= 1'b0;
          cnt_q <= '0;
          unique case (phase_q)
            PH_ADDR: phase_q <= PH_SUB;
            PH_SUB: begin
              ptr_q   <= shreg_q;
              phase_q <= PH_DATA;
            end
            PH_DATA: begin
              if (in_range) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= ptr_q[IDX_W-1:0];
                wr_data_o <= shreg_q;
                ptr_q     <= ptr_q + BYTE_W'(1);
              end
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eq_band_regs.sv
module eq_band_regs
  import eq_pkg::*;
#(
  parameter int NUM_REGS = NUM_BANDS,
  parameter int WIDTH    = CODE_W,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  output logic [NUM_REGS*WIDTH-1:0] boost_o,
  output logic [NUM_REGS*WIDTH-1:0] cut_o
);
  logic bypass_q;
  logic unused_bit3;

  assign unused_bit3 = wr_data_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            bypass_q <= 1'b0;
    else if (wr_en_i && wr_idx_i == '0)     bypass_q <= wr_data_i[BYP_BIT];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_band
    logic [WIDTH-1:0] boost_q, cut_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        boost_q <= '0;
        cut_q   <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        boost_q <= wr_data_i[BOOST_LSB +: WIDTH];
        cut_q   <= wr_data_i[CUT_LSB +: WIDTH];
      end
    end

    // bypass forces the flat code, storage untouched
    assign boost_o[g*WIDTH +: WIDTH] = bypass_q ? '0 : boost_q;
    assign cut_o[g*WIDTH +: WIDTH]   = bypass_q ? '0 : cut_q;
  end
endmodule

// File: rtl/eq_i2c_regs.sv
module eq_i2c_regs
  import eq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         NUM_REGS = NUM_BANDS,
  parameter int         WIDTH    = CODE_W,
  localparam int        IDX_W    = $clog2(NUM_REGS),
  localparam int        OUT_W    = NUM_REGS * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel_i,
  output logic             sda_oe_o,
  output logic [OUT_W-1:0] boost_o,
  output logic [OUT_W-1:0] cut_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  eq_bus_sync i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eq_i2c_rx #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .addr_sel_i (addr_sel_i),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  eq_band_regs #(
    .NUM_REGS (NUM_REGS),
    .WIDTH    (WIDTH),
    .IDX_W    (IDX_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .boost_o   (boost_o),
    .cut_o     (cut_o)
  );
endmodule

// File: rtl/eq_chk.sv
module eq_chk #(
  parameter int NUM_REGS = 5,
  parameter int IDX_W    = 3,
  parameter int OUT_W    = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [7:0]       wr_data,
  input logic [OUT_W-1:0] boost_o,
  input logic [OUT_W-1:0] cut_o
);
  p_ack_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  p_release_on_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  p_idx_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  p_bypass_flat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_idx == '0 && wr_data[7]) |=> (boost_o == '0 && cut_o == '0));

  p_commit_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> $past(sda_oe_o));

  p_hold_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ($stable(boost_o) && $stable(cut_o)));

  p_restart_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
endmodule

bind eq_i2c_regs eq_chk #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W),
  .OUT_W    (OUT_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .boost_o   (boost_o),
  .cut_o     (cut_o)
);

// File: tb/test_eq_i2c_regs.sv
`timescale 1ns/1ps
module test_eq_i2c_regs;
  localparam int H = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic        sel_drv = 1'b0;
  logic        sda_oe_o;
  logic [14:0] boost_o, cut_o;
  logic        sda_bus;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [2:0] m_boost [5];
  logic [2:0] m_cut   [5];
  logic       m_byp;
  logic [7:0] pl [8];

  always #2 clk_i = ~clk_i;
  assign sda_bus = sda_drv & ~sda_oe_o;

  eq_i2c_regs i_eq_i2c_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_drv),
    .sda_i      (sda_bus),
    .addr_sel_i (sel_drv),
    .sda_oe_o   (sda_oe_o),
    .boost_o    (boost_o),
    .cut_o      (cut_o)
  );

  function automatic logic [14:0] exp_boost();
    logic [14:0] v;
    for (int i = 0; i < 5; i++) v[i*3 +: 3] = m_byp ? 3'd0 : m_boost[i];
    return v;
  endfunction

  function automatic logic [14:0] exp_cut();
    logic [14:0] v;
    for (int i = 0; i < 5; i++) v[i*3 +: 3] = m_byp ? 3'd0 : m_cut[i];
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    check(boost_o == exp_boost(), tag, 32'(boost_o), 32'(exp_boost()));
    check(cut_o == exp_cut(), tag, 32'(cut_o), 32'(exp_cut()));
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; tick(H);
    scl_drv = 1'b1; tick(H);
    sda_drv = 1'b0; tick(H);
    scl_drv = 1'b0;
  endtask

  task automatic i2c_stop();
    tick(3); sda_drv = 1'b0; tick(H);
    scl_drv = 1'b1; tick(H);
    sda_drv = 1'b1; tick(H);
  endtask

  task automatic send_bit(logic b);
    tick(3); sda_drv = b; tick(H);
    scl_drv = 1'b1; tick(H);
    scl_drv = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    tick(3); sda_drv = 1'b1; tick(H);
    scl_drv = 1'b1; tick(H/2);
    ack = (sda_bus == 1'b0);
    tick(H - H/2);
    scl_drv = 1'b0;
  endtask

  task automatic model_write(logic [7:0] sub, int n);
    int p = int'(sub);
    for (int k = 0; k < n; k++) begin
      if (p < 5) begin
        m_boost[p] = pl[k][6:4];
        m_cut[p]   = pl[k][2:0];
        if (p == 0) m_byp = pl[k][7];
        p++;
      end
    end
  endtask

  task automatic xfer(logic sel, logic [7:0] abyte, logic [7:0] sub, int n, string tag);
    bit ack, match;
    sel_drv = sel; tick(2);
    match = (abyte == (sel ? 8'h86 : 8'h84));
    i2c_start();
    send_byte(abyte, ack);
    check(ack == match, match ? "R2 addr ack" : "R3 addr nack", 32'(ack), 32'(match));
    send_byte(sub, ack);
    check(ack == match, match ? "R2 sub ack" : "R3 sub ignored", 32'(ack), 32'(match));
    for (int k = 0; k < n; k++) begin
      send_byte(pl[k], ack);
      check(ack == match, match ? "R6 data ack" : "R3 data ignored", 32'(ack), 32'(match));
    end
    i2c_stop();
    if (match) model_write(sub, n);
    check_out(tag);
  endtask

  initial begin
    repeat (180000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 5; i++) begin m_boost[i] = 3'd0; m_cut[i] = 3'd0; end
    m_byp = 1'b0;
    tick(5); rst_ni = 1'b1; tick(5);

    // R1 reset state
    check(boost_o == '0 && cut_o == '0, "R1 reset codes", 32'(boost_o), 32'd0);
    check(sda_oe_o == 1'b0, "R1 reset oe", 32'(sda_oe_o), 32'd0);

    // R4 field placement, bit 3 ignored
    pl[0] = 8'h3D; xfer(1'b0, 8'h84, 8'h00, 1, "R4 band0 fields");
    pl[0] = 8'h52; xfer(1'b1, 8'h86, 8'h01, 1, "R2 strap high addr");

    // R5 burst over all bands, R6 overrun discarded
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33; pl[3] = 8'h44;
    pl[4] = 8'h55; pl[5] = 8'h77; pl[6] = 8'h66;
    xfer(1'b0, 8'h84, 8'h00, 7, "R5 auto increment");
    pl[0] = 8'h77; xfer(1'b0, 8'h84, 8'h06, 1, "R6 unused pointer");

    // R7 bypass
    pl[0] = 8'hC1; xfer(1'b0, 8'h84, 8'h00, 1, "R7 bypass on");
    pl[0] = 8'hF3; xfer(1'b0, 8'h84, 8'h02, 1, "R7 band2 bit7 under bypass");
    pl[0] = 8'h41; xfer(1'b0, 8'h84, 8'h00, 1, "R7 bypass off restores");

    // R3 wrong address and read bit
    pl[0] = 8'h00; xfer(1'b1, 8'h84, 8'h00, 1, "R3 wrong strap");
    pl[0] = 8'h00; xfer(1'b0, 8'h85, 8'h00, 1, "R3 read bit");

    // R8 byte cut short by stop
    sel_drv = 1'b0; tick(2);
    i2c_start();
    send_byte(8'h84, ack); send_byte(8'h03, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_stop();
    check_out("R8 aborted byte");

    // R9 repeated start replaces pointer
    i2c_start();
    send_byte(8'h84, ack); send_byte(8'h01, ack);
    i2c_start();
    send_byte(8'h84, ack);
    check(ack, "R9 restart addr ack", 32'(ack), 32'd1);
    send_byte(8'h04, ack); send_byte(8'h26, ack);
    i2c_stop();
    pl[0] = 8'h26; model_write(8'h04, 1);
    check_out("R9 restart pointer");

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic       sel;
      logic [7:0] ab;
      int         r, n;
      sel = 1'($urandom_range(0, 1));
      r   = int'($urandom_range(0, 9));
      if (r < 7)       ab = sel ? 8'h86 : 8'h84;
      else if (r == 7) ab = sel ? 8'h84 : 8'h86;
      else if (r == 8) ab = (sel ? 8'h86 : 8'h84) | 8'h01;
      else             ab = 8'($urandom);
      n = int'($urandom_range(1, 6));
      for (int k = 0; k < 8; k++) pl[k] = 8'($urandom);
      xfer(sel, ab, 8'($urandom_range(0, 7)), n, "R4 random transfer");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule